// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock of an I2C controller from a fast functional clock. A programmable divider turns the functional clock into a slower timing tick. The clock line is then held low for a programmed number of ticks plus seven, and left released for a programmed number of ticks plus five. The block never drives the line high. It only pulls the line low or lets it go, and it watches the wire so that a target can hold the clock low to slow the transfer down.

The transfer engine next to it gets two single-cycle strobes. One comes in the middle of each low phase, when SDA may change. The other comes in the middle of each high phase, when SDA is sampled. The divider and both phase counts are captured from a write port. A write lands only while the generator is disabled, so a live clock is never reshaped mid-transfer. Clearing the enable releases the line at once and parks every counter.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, and from reset, `scl_drive_low` is 0 and neither strobe is asserted. Dropping `enable` releases the line on the next cycle.
- R2: A tick occurs every `div + 1` functional clocks. The line is driven low for exactly `(low + 7) * (div + 1)` clocks per phase.
- R3: The high phase starts one clock after `scl_in` is first seen high. It lasts `(high + 5) * (div + 1)` clocks, so an unstretched released interval is `1 + (high + 5) * (div + 1)` clocks.
- R4: If the target holds `scl_in` low for S clocks after release, the released interval grows by exactly S clocks. The low drive time does not change.
- R5: `drive_stb` pulses once per low phase, at clock index `((low + 7) / 2) * (div + 1) + div` counted from the first low clock (integer division, index 0 = first clock).
- R6: `sample_stb` pulses once per released interval, at clock index `S + 1 + ((high + 5) / 2) * (div + 1) + div` counted from the first released clock.
- R7: A configuration write (`cfg_we` high) while `enable` is high has no effect. The following phases keep the earlier timing.
- R8: After a disable and a re-enable, the first low phase has its full length under the configuration written while disabled.
- R9: The extremes `div = 0` (a tick every clock) and `low = high = 255` (262-tick low, 260-tick high) give the lengths of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Generator enable; configuration writes are accepted only while low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 8 | Tick divider; tick period is value + 1 clocks |
| cfg_low | input | 8 | Low phase count; phase is value + 7 ticks |
| cfg_high | input | 8 | High phase count; phase is value + 5 ticks |
| scl_in | input | 1 | Sampled level of the clock wire |
| scl_drive_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| drive_stb | output | 1 | One-clock pulse in the middle of the low phase |
| sample_stb | output | 1 | One-clock pulse in the middle of the high phase |

## Verification
Every output comes straight from registered phase state and the tick comparator. A change of `enable` shows on `scl_drive_low` one clock later, and the high phase begins one clock after the clock edge at which the wire is first seen high. The bench measures whole phases as run lengths of `scl_drive_low` and records where each strobe falls inside its run. The expected lengths and positions are computed from the R2–R6 formulas, counted in functional clocks from the first clock of each run, and the bench samples on the falling edge. A first measurement after a reconfiguration syncs to a fresh low phase, except in the re-enable case, where the first run is measured from its own start.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int DIV_W      = 8;
    localparam int CNT_W      = 8;
    localparam int LOW_EXTRA  = 7;
    localparam int HIGH_EXTRA = 5;
    localparam int LEN_W      = CNT_W + 1;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
    } scl_cfg_t;

    function automatic logic [LEN_W-1:0] phase_ticks(input logic [CNT_W-1:0] val,
                                                     input int extra);
        return LEN_W'(val) + LEN_W'(extra);
    endfunction

    function automatic logic [LEN_W-1:0] mid_tick(input logic [LEN_W-1:0] len);
        return len >> 1;
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_timing_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     we,
    input  scl_cfg_t wr_cfg,
    output scl_cfg_t cfg
);

    scl_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we && !enable) begin
            cfg_q <= wr_cfg;
        end
    end

    assign cfg = cfg_q;

    // R7
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(cfg_q));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && !restart && (cnt_q == div);

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= div);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       tick,
    input  logic       scl_in,
    input  scl_cfg_t   cfg,
    output scl_phase_e phase,
    output logic       drive_low,
    output logic       drive_stb,
    output logic       sample_stb
);

    scl_phase_e       ph_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;

    assign low_len  = phase_ticks(cfg.low, LOW_EXTRA);
    assign high_len = phase_ticks(cfg.high, HIGH_EXTRA);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ph_q  <= PH_OFF;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_OFF: begin
                    ph_q  <= PH_LOW;
                    cnt_q <= '0;
                end
                PH_LOW: begin
                    if (tick) begin
                        if (cnt_q == low_len - 1'b1) begin
                            ph_q  <= PH_WAIT;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    cnt_q <= '0;
                    if (scl_in) begin
                        ph_q <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        if (cnt_q == high_len - 1'b1) begin
                            ph_q  <= PH_LOW;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    ph_q  <= PH_OFF;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phase      = ph_q;
    assign drive_low  = (ph_q == PH_LOW);
    assign drive_stb  = tick && (ph_q == PH_LOW)  && (cnt_q == mid_tick(low_len));
    assign sample_stb = tick && (ph_q == PH_HIGH) && (cnt_q == mid_tick(high_len));

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WAIT) && !scl_in && enable |=> (ph_q == PH_WAIT));

    // R3
    high_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HIGH) && ($past(ph_q) != PH_HIGH) |-> $past(scl_in));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb
);

    scl_cfg_t   wr_cfg;
    scl_cfg_t   cfg;
    scl_phase_e phase;
    logic       tick;
    logic       hold_div;

    assign wr_cfg = '{div: cfg_div, low: cfg_low, high: cfg_high};

    scl_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg    (cfg)
    );

    assign hold_div = (phase == PH_OFF) || (phase == PH_WAIT);

    scl_prescaler u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (enable),
        .restart (hold_div),
        .div     (cfg.div),
        .tick    (tick)
    );

    scl_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .tick       (tick),
        .scl_in     (scl_in),
        .cfg        (cfg),
        .phase      (phase),
        .drive_low  (scl_drive_low),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    // R1
    off_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !scl_drive_low && !drive_stb && !sample_stb);

    // R5
    drive_mid_chk: assert property (@(posedge clk) disable iff (rst)
        drive_stb && enable |=> scl_drive_low);

    // R6
    sample_mid_chk: assert property (@(posedge clk) disable iff (rst)
        sample_stb && enable |=> !scl_drive_low);

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_div = '0;
    logic [7:0] cfg_low = '0;
    logic [7:0] cfg_high = '0;
    logic       scl_in;
    logic       scl_drive_low;
    logic       drive_stb;
    logic       sample_stb;

    int n_checks = 0;
    int n_fails  = 0;
    int stretch_len = 0;
    int rel_cnt = 0;
    logic stretch_hold;

    always #10 clk = ~clk;

    always @(posedge clk) rel_cnt <= scl_drive_low ? 0 : rel_cnt + 1;
    assign stretch_hold = !scl_drive_low && (rel_cnt < stretch_len);
    assign scl_in = !scl_drive_low && !stretch_hold;

    scl_timing_gen u_scl_timing_gen (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .cfg_we        (cfg_we),
        .cfg_div       (cfg_div),
        .cfg_low       (cfg_low),
        .cfg_high      (cfg_high),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .drive_stb     (drive_stb),
        .sample_stb    (sample_stb)
    );

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int d, input int l, input int h);
        @(negedge clk);
        cfg_div = 8'(d); cfg_low = 8'(l); cfg_high = 8'(h); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic measure(input bit skip, output int lo, output int rel,
                           output int dpos, output int spos,
                           output int dn, output int sn);
        lo = 0; rel = 0; dpos = -1; spos = -1; dn = 0; sn = 0;
        @(negedge clk);
        if (skip) begin
            while (scl_drive_low) @(negedge clk);
            while (!scl_drive_low) @(negedge clk);
        end
        while (scl_drive_low) begin
            if (drive_stb) begin dpos = lo; dn++; end
            lo++;
            @(negedge clk);
        end
        while (!scl_drive_low) begin
            if (sample_stb) begin spos = rel; sn++; end
            rel++;
            @(negedge clk);
        end
    endtask

    task automatic run_timing(input int d, input int l, input int h, input int s,
                              input string tag);
        int lo, rel, dpos, spos, dn, sn;
        int dd, ll, hh;
        dd = d + 1; ll = l + 7; hh = h + 5;
        stretch_len = s;
        measure(1'b1, lo, rel, dpos, spos, dn, sn);
        check(lo, ll * dd, {tag, " R2 low width"});
        check(rel, s + 1 + hh * dd, {tag, " R3/R4 released width"});
        check(dn, 1, {tag, " R5 drive strobe count"});
        check(dpos, (ll / 2) * dd + d, {tag, " R5 drive strobe position"});
        check(sn, 1, {tag, " R6 sample strobe count"});
        check(spos, s + 1 + (hh / 2) * dd + d, {tag, " R6 sample strobe position"});
        stretch_len = 0;
    endtask

    task automatic test_reset();
        int busy = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (scl_drive_low || drive_stb || sample_stb) busy++;
        end
        check(busy, 0, "R1 idle after reset");
    endtask

    task automatic test_defaults();
        @(negedge clk); enable = 1'b1;
        run_timing(0, 0, 0, 0, "defaults R9");
        @(negedge clk); enable = 1'b0;
    endtask

    task automatic test_config(input int d, input int l, input int h, input string tag);
        write_cfg(d, l, h);
        @(negedge clk); enable = 1'b1;
        run_timing(d, l, h, 0, tag);
    endtask

    task automatic test_stretch();
        int lo, rel, dpos, spos, dn, sn;
        run_timing(1, 2, 0, 7, "stretch R4");
        stretch_len = 3;
        measure(1'b1, lo, rel, dpos, spos, dn, sn);
        check(lo, 18, "R4 low width unchanged by stretch");
        check(rel - 3, 11, "R4 bus high time after stretch");
        stretch_len = 0;
    endtask

    task automatic test_locked_write();
        write_cfg(9, 50, 50);
        run_timing(1, 2, 0, 0, "locked R7");
    endtask

    task automatic test_disable_reenable();
        int busy = 0;
        int lo, rel, dpos, spos, dn, sn;
        @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(int'(scl_drive_low), 0, "R1 release one clock after disable");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low || drive_stb || sample_stb) busy++;
        end
        check(busy, 0, "R1 quiet while disabled");
        write_cfg(0, 255, 255);
        @(negedge clk); enable = 1'b1;
        measure(1'b0, lo, rel, dpos, spos, dn, sn);
        check(lo, 262, "R8 full first low after re-enable");
        check(dpos, 131, "R8 drive strobe on first low");
        check(rel, 261, "R9 max high released width");
        check(spos, 131, "R9 max high sample strobe position");
        @(negedge clk); enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_defaults();
        test_config(3, 13, 15, "standard R2");
        @(negedge clk); enable = 1'b0;
        test_config(1, 2, 0, "small R3");
        test_stretch();
        test_locked_write();
        test_disable_reenable();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule